// File: doc/BRIEF.md
# Expansion Bus Slow Target

This block sits on the target side of an 8-bit PC-style expansion bus and serves a small window of four I/O registers. The 20-bit bus address is followed while the latch strobe is high and held once the strobe drops. A cycle counts as a processor cycle only when the DMA grant line is low, both when the address is latched and when the command arrives. When the held address falls inside the window and a read or write command is active, the block pulls ready low. It then hands the access to an internal register interface through a request/done handshake.

Ready stays low until the register side signals completion, or until a hard cycle limit expires, whichever comes first. The limit is derived from the bus clock period and a microsecond budget, so it stays under the budget in both the fast and the slow clock mode. An expired wait sets a sticky flag and returns all-ones on a read. For register sides with no done line, a parameter selects an internal fixed wait count instead. The data bus is driven only during an accepted read while the read strobe is low. The bus is modelled as separate in/out values plus an output enable.

Top module: `ebt_slow_target`

## Requirements
- R1: While reset is asserted and right after it, ready_o is 1, data_oe_o is 0, reg_req_o is 0 and timeout_flag_o is 0.
- R2: On every clock with ale_i high, the address and the DMA grant are sampled. Once ale_i is low, the held address decides the response, whatever addr_i does afterwards. A cycle is only accepted with ale_i low.
- R3: No cycle is accepted if dma_grant_i was high when the address was latched, or if it is high when the command is seen. In such cases ready_o stays 1.
- R4: The window is BASE_ADDR with address bits 1:0 cleared, spanning four registers. reg_sel_o equals held address bits 1:0. An address that differs in any of bits 19:2 is ignored: ready_o stays 1 and data_oe_o stays 0.
- R5: When a matching address meets an active command (ior_ni or iow_ni low), ready_o goes low on the next clock edge. reg_req_o is high for exactly as long as ready_o is low.
- R6: reg_done_i sampled high during a wait returns ready_o to 1 on that edge. On a read, reg_rdata_i is captured at that edge and appears on data_o.
- R7: ready_o is never low for more than TO_CYC = LIMIT_NS/CLK_NS - 1 consecutive clocks. At that limit, ready_o is released, timeout_flag_o is set and a read returns 8'hFF.
- R8: timeout_flag_o, once set, stays 1 until reset.
- R9: Releasing the command ends the access: data_oe_o falls in the same cycle, and ready_o is 1 after the next edge, even mid-wait.
- R10: In a write access, reg_we_o is 1 while reg_req_o is 1, and reg_wdata_o holds data_i as sampled at the accepting edge.
- R11: With USE_DONE = 0, ready_o stays low for exactly WAIT_CYC clocks, unless the cycle limit or a high reg_done_i ends the wait first.
- R12: If done and the last allowed wait cycle coincide, done wins: the wait ends normally and timeout_flag_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Bus address |
| ale_i | input | 1 | Address latch strobe, active high |
| dma_grant_i | input | 1 | DMA controller owns the bus, active high |
| ior_ni | input | 1 | I/O read command, active low |
| iow_ni | input | 1 | I/O write command, active low |
| data_i | input | DW | Data bus value seen by the target |
| data_o | output | DW | Read data driven onto the bus |
| data_oe_o | output | 1 | Data bus drive enable |
| ready_o | output | 1 | Bus ready, low inserts wait states |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | Register access is a write |
| reg_sel_o | output | 2 | Register index inside the window |
| reg_wdata_o | output | DW | Write data to registers |
| reg_rdata_i | input | DW | Read data from registers |
| reg_done_i | input | 1 | Register access complete |
| timeout_flag_o | output | 1 | Sticky wait-limit-expired flag |

## Verification
Some properties are checked on every cycle. The assertions check that an accepted match drops ready, that the last allowed wait cycle releases ready and raises the flag, that a released command or a DMA grant leaves ready high on the next edge, that the flag never clears, and that the held register index is stable while the strobe is low. Other behaviour needs the bench's scenarios. These are the exact wait length for a given done delay, the timeout length and the all-ones read, and the priority of done over timeout. They also include the internal wait count and the address that changes after the strobe falls. The bench covers all of these with a behavioural reference compared on every clock, plus measured ready-low lengths.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } ebt_state_e;
endpackage

// File: rtl/ebt_addr_latch.sv
module ebt_addr_latch #(
  parameter int unsigned AW = 20,
  parameter logic [AW-1:0] BASE_ADDR = 20'h00300
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic          grant_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [1:0]    sel_o
);
  logic [AW-1:0] addr_q;
  logic          cpu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cpu_q  <= 1'b0;
    end else if (ale_i) begin
      addr_q <= addr_i;
      cpu_q  <= !grant_i;
    end
  end

  assign hit_o = cpu_q && !ale_i && !grant_i &&
                 (addr_q[AW-1:2] == BASE_ADDR[AW-1:2]);
  assign sel_o = addr_q[1:0];

  // R2: held address does not move while the strobe is low
  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(sel_o));
endmodule

// File: rtl/ebt_wait_ctrl.sv
module ebt_wait_ctrl
  import ebt_pkg::*;
#(
  parameter int unsigned TO_CYC   = 119,
  parameter bit          USE_DONE = 1'b1,
  parameter int unsigned WAIT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic cmd_i,
  input  logic done_i,
  output logic start_o,
  output logic finish_o,
  output logic timeout_o,
  output logic busy_o,
  output logic req_o,
  output logic ready_o,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(TO_CYC + 1);

  ebt_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          done_eff;
  logic          last_cyc;

  generate
    if (USE_DONE) begin : g_ext_done
      assign done_eff = done_i;
    end else begin : g_int_done
      // fixed wait models a slow device; an external done may still cut it short
      assign done_eff = done_i || (cnt_q == CW'(WAIT_CYC - 1));
    end
  endgenerate

  assign last_cyc  = (cnt_q == CW'(TO_CYC - 1));
  assign start_o   = (state_q == ST_IDLE) && hit_i && cmd_i;
  assign finish_o  = (state_q == ST_WAIT) && cmd_i && done_eff;
  assign timeout_o = (state_q == ST_WAIT) && cmd_i && !done_eff && last_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_o) begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
        end
        ST_WAIT: begin
          if (!cmd_i) state_q <= ST_IDLE;
          else if (done_eff) state_q <= ST_HOLD;
          else if (last_cyc) begin
            state_q <= ST_HOLD;
            flag_q  <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD: if (!cmd_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign req_o   = (state_q == ST_WAIT);
  assign ready_o = (state_q != ST_WAIT);
  assign flag_o  = flag_q;

  a_r5_match_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && hit_i && cmd_i) |=> !ready_o);

  a_r7_limit_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && cmd_i && !done_eff && last_cyc) |=> (ready_o && flag_o));

  a_r9_release_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i |=> ready_o);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> flag_o);
endmodule

// File: rtl/ebt_data_path.sv
module ebt_data_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          finish_i,
  input  logic          timeout_i,
  input  logic          busy_i,
  input  logic          req_i,
  input  logic          rd_cmd_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          reg_we_o,
  output logic [1:0]    reg_sel_o,
  output logic [DW-1:0] reg_wdata_o
);
  logic          rd_q;
  logic [1:0]    sel_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      sel_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start_i) begin
        rd_q    <= rd_cmd_i;
        sel_q   <= sel_i;
        wdata_q <= data_i;
      end
      if (finish_i)       rdata_q <= reg_rdata_i;
      else if (timeout_i) rdata_q <= '1;
    end
  end

  assign data_o      = rdata_q;
  assign data_oe_o   = busy_i && rd_q && rd_cmd_i;
  assign reg_we_o    = req_i && !rd_q;
  assign reg_sel_o   = sel_q;
  assign reg_wdata_o = wdata_q;
endmodule

// File: rtl/ebt_slow_target.sv
module ebt_slow_target #(
  parameter int unsigned   AW        = 20,
  parameter int unsigned   DW        = 8,
  parameter logic [AW-1:0] BASE_ADDR = 20'h00300,
  parameter int unsigned   CLK_NS    = 125,
  parameter int unsigned   LIMIT_NS  = 15000,
  parameter bit            USE_DONE  = 1'b1,
  parameter int unsigned   WAIT_CYC  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ale_i,
  input  logic          dma_grant_i,
  input  logic          ior_ni,
  input  logic          iow_ni,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          ready_o,
  output logic          reg_req_o,
  output logic          reg_we_o,
  output logic [1:0]    reg_sel_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic          reg_done_i,
  output logic          timeout_flag_o
);
  // one cycle below the budget so the low time stays strictly under it
  localparam int unsigned TO_CYC = LIMIT_NS / CLK_NS - 1;

  logic       hit, cmd, rd_cmd;
  logic [1:0] sel;
  logic       start, finish, timeout, busy, req;

  assign rd_cmd = !ior_ni;
  assign cmd    = !ior_ni || !iow_ni;

  ebt_addr_latch #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .grant_i(dma_grant_i),
    .addr_i (addr_i),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  ebt_wait_ctrl #(.TO_CYC(TO_CYC), .USE_DONE(USE_DONE), .WAIT_CYC(WAIT_CYC)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .cmd_i    (cmd),
    .done_i   (reg_done_i),
    .start_o  (start),
    .finish_o (finish),
    .timeout_o(timeout),
    .busy_o   (busy),
    .req_o    (req),
    .ready_o  (ready_o),
    .flag_o   (timeout_flag_o)
  );

  ebt_data_path #(.DW(DW)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .finish_i   (finish),
    .timeout_i  (timeout),
    .busy_i     (busy),
    .req_i      (req),
    .rd_cmd_i   (rd_cmd),
    .sel_i      (sel),
    .data_i     (data_i),
    .reg_rdata_i(reg_rdata_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .reg_we_o   (reg_we_o),
    .reg_sel_o  (reg_sel_o),
    .reg_wdata_o(reg_wdata_o)
  );

  assign reg_req_o = req;

  a_r3_dma_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_grant_i && ready_o) |=> ready_o);
endmodule

// File: tb/tb_ebt_slow_target.sv
`timescale 1ns/1ps
module tb_ebt_slow_target;
  localparam logic [19:0] BASE = 20'h00300;
  localparam int TO = 1500 / 125 - 1;
  localparam int WC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic ale = 1'b0, grant = 1'b0, ior_n = 1'b1, iow_n = 1'b1, done = 1'b0;
  logic [7:0] din = '0, rdata = 8'h5A;
  logic [7:0] data_o, wdata_o;
  logic oe, ready, req, we, flag;
  logic [1:0] sel_o;
  logic [7:0] w_data_o, w_wdata;
  logic w_oe, w_ready, w_req, w_we, w_flag;
  logic [1:0] w_sel;

  int checks = 0, fails = 0;
  int low_cnt = 0, low_w = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ebt_slow_target #(.BASE_ADDR(BASE), .CLK_NS(125), .LIMIT_NS(1500), .USE_DONE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ale_i(ale), .dma_grant_i(grant),
    .ior_ni(ior_n), .iow_ni(iow_n), .data_i(din), .data_o(data_o), .data_oe_o(oe),
    .ready_o(ready), .reg_req_o(req), .reg_we_o(we), .reg_sel_o(sel_o),
    .reg_wdata_o(wdata_o), .reg_rdata_i(rdata), .reg_done_i(done), .timeout_flag_o(flag));

  ebt_slow_target #(.BASE_ADDR(BASE), .USE_DONE(1'b0), .WAIT_CYC(WC)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ale_i(ale), .dma_grant_i(grant),
    .ior_ni(ior_n), .iow_ni(iow_n), .data_i(din), .data_o(w_data_o), .data_oe_o(w_oe),
    .ready_o(w_ready), .reg_req_o(w_req), .reg_we_o(w_we), .reg_sel_o(w_sel),
    .reg_wdata_o(w_wdata), .reg_rdata_i(8'h00), .reg_done_i(1'b0), .timeout_flag_o(w_flag));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", rq, $time, act, exp);
    end
  endtask

  // behavioural reference
  int m_st = 0, m_n = 0;
  bit m_rd = 0, m_flag = 0, m_cpu = 0;
  logic [19:0] m_addr = '0;
  logic [7:0] m_rdata = '0, m_wdata = '0;
  logic [1:0] m_sel = '0;

  always @(posedge clk or negedge rst_n) begin : model
    bit cmd;
    if (!rst_n) begin
      m_st = 0; m_n = 0; m_rd = 0; m_flag = 0; m_cpu = 0;
      m_addr = '0; m_rdata = '0; m_wdata = '0; m_sel = '0;
    end else begin
      cmd = !ior_n || !iow_n;
      case (m_st)
        0: if (!ale && !grant && m_cpu && m_addr[19:2] == BASE[19:2] && cmd) begin
             m_st = 1; m_n = 0; m_rd = !ior_n; m_sel = m_addr[1:0]; m_wdata = din;
           end
        1: if (!cmd) m_st = 0;
           else if (done) begin m_st = 2; m_rdata = rdata; end
           else if (m_n == TO - 1) begin m_st = 2; m_flag = 1; m_rdata = 8'hFF; end
           else m_n++;
        default: if (!cmd) m_st = 0;
      endcase
      if (ale) begin m_addr = addr; m_cpu = !grant; end
    end
  end

  always @(negedge clk) begin
    if (!ready) low_cnt++;
    if (!w_ready) low_w++;
    if (rst_n) begin
      chk(ready == (m_st != 1), "R5 ready", ready, m_st != 1);
      chk(req == (m_st == 1), "R5 req", req, m_st == 1);
      chk(oe == (m_st != 0 && m_rd && !ior_n), "R9 oe", oe, m_st != 0 && m_rd && !ior_n);
      chk(flag == m_flag, "R8 flag", flag, m_flag);
      if (m_st == 2 && m_rd) chk(data_o == m_rdata, "R6 data", data_o, m_rdata);
      if (m_st == 1 && !m_rd) chk(we && wdata_o == m_wdata, "R10 write", {we, wdata_o}, {1'b1, m_wdata});
      if (m_st != 0) chk(sel_o == m_sel, "R4 sel", sel_o, m_sel);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // one bus access: latch, command, hold for n cycles (done on cycle dly, -1 none), release
  task automatic bus_cycle(input logic [19:0] a, input bit g_latch, input bit g_cmd,
                           input bit rd, input logic [7:0] wd, input int dly, input int n);
    low_cnt = 0; low_w = 0;
    ale = 1; addr = a; grant = g_latch; step();
    ale = 0; addr = 20'hFFFFF; grant = g_cmd; din = wd;
    ior_n = !rd; iow_n = rd; step();
    for (int k = 0; k < n; k++) begin
      done = (k == dly);
      step();
    end
    done = 0; ior_n = 1; iow_n = 1; grant = 0; step();
    step();
  endtask

  initial begin
    #1;
    chk(ready && !oe && !req && !flag, "R1 in reset", {ready, oe, req, flag}, 4'b1000);
    step(); step();
    rst_n = 1; step();
    chk(ready && !oe && !req && !flag, "R1 after reset", {ready, oe, req, flag}, 4'b1000);

    bus_cycle(BASE + 1, 0, 0, 1, 8'h00, 2, 5);
    chk(low_cnt == 3, "R6 done ends wait (R2 addr held)", low_cnt, 3);
    chk(low_w == WC, "R11 internal wait", low_w, WC);

    rdata = 8'h3C;
    bus_cycle(BASE + 3, 0, 0, 0, 8'hA5, 0, 3);
    chk(low_cnt == 1, "R10 write one wait", low_cnt, 1);

    bus_cycle(BASE + 4, 0, 0, 1, 8'h00, 0, 4);
    chk(low_cnt == 0, "R4 outside window", low_cnt, 0);
    bus_cycle(BASE | 20'h10000, 0, 0, 0, 8'h11, 0, 4);
    chk(low_cnt == 0, "R4 upper bit differs", low_cnt, 0);

    bus_cycle(BASE, 1, 0, 1, 8'h00, 0, 4);
    chk(low_cnt == 0, "R3 grant at latch", low_cnt, 0);
    bus_cycle(BASE, 0, 1, 0, 8'h22, 0, 4);
    chk(low_cnt == 0, "R3 grant at command", low_cnt, 0);

    bus_cycle(BASE + 2, 0, 0, 1, 8'h00, -1, 2);
    chk(low_cnt == 3, "R9 early release", low_cnt, 3);

    rdata = 8'h77;
    bus_cycle(BASE + 2, 0, 0, 1, 8'h00, TO - 1, TO + 3);
    chk(low_cnt == TO, "R12 done at limit", low_cnt, TO);
    chk(!flag, "R12 no flag", flag, 0);

    // timeout read: check data while command still held
    low_cnt = 0;
    ale = 1; addr = BASE; step();
    ale = 0; ior_n = 0; step();
    for (int k = 0; k < TO + 3; k++) step();
    chk(low_cnt == TO, "R7 wait capped", low_cnt, TO);
    chk(flag, "R7 flag set", flag, 1);
    chk(oe && data_o == 8'hFF, "R7 all ones", {oe, data_o}, {1'b1, 8'hFF});
    ior_n = 1; step(); step();

    rdata = 8'h5A;
    bus_cycle(BASE + 1, 0, 0, 1, 8'h00, 1, 3);
    chk(flag && low_cnt == 2, "R8 flag persists", {flag, low_cnt[7:0]}, {1'b1, 8'd2});

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule